// File: doc/BRIEF.md
# Stop Mode Entry and Wake Controller

This block runs the deepest halt state of a small 8-bit processor. When the core signals that a stop opcode has executed, the block either halts every clock, the crystal oscillator included, or, if stop is disabled by the flag bit, answers with a no-op acknowledge and leaves all clocks running. While halted it watches the active-low interrupt and reset pins and a pending edge-latched interrupt flag. It decides which of them may wake the part, and in which order they count.

On a wake the oscillator is restarted at once. The core clock stays gated off for a settling time taken from a programmable count. When that time ends, the block releases the core clock and hands the CPU sequencer a one-cycle action code. The code says whether to take the maskable interrupt, take the nonmaskable interrupt, continue with the next instruction, or run a full reset.

Top module: `stop_wake_ctrl`

## Requirements
- R1: A stop strobe with the stop-disable bit at 0 makes osc_en and core_clk_en 0, and stop_active 1, from the next cycle on.
- R2: A stop strobe with the stop-disable bit at 1 gives nop_ack high for exactly the next cycle, while osc_en and core_clk_en stay 1 and stop_active stays 0.
- R3: While halted with no qualified wake source, the block stays halted (osc_en 0) for any number of cycles, and further stop strobes are ignored (nop_ack stays 0).
- R4: A low irq_n or a set irq_edge_pend wakes the block only when irq_mask is 0. With irq_mask at 1 both are ignored and osc_en stays 0.
- R5: A low xirq_n wakes the block whatever the value of xirq_mask.
- R6: The action code is 1 (take IRQ) for an IRQ wake. For an XIRQ wake it is 2 (take XIRQ) when xirq_mask was 0 and 3 (continue with next instruction) when xirq_mask was 1.
- R7: A low rst_pin_n while halted wakes the block with action code 4 (full reset).
- R8: When several sources are active in the same halted cycle, reset beats XIRQ and XIRQ beats IRQ.
- R9: osc_en rises in the cycle after the wake. core_clk_en stays 0 for exactly N further cycles, where N is settle_cnt, and a settle_cnt of 0 selects the default of 4064.
- R10: stop_active stays 1 from entry until core_clk_en returns. wake_valid is 1 for exactly that first cycle with the core clock back, and wake_action is nonzero only while wake_valid is 1 (code 0 otherwise).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Power-on reset, active low |
| stop_exec | input | 1 | One-cycle strobe: stop opcode executed |
| stop_dis | input | 1 | Stop-disable flag bit |
| irq_mask | input | 1 | Maskable interrupt mask bit |
| xirq_mask | input | 1 | Nonmaskable interrupt mask bit |
| irq_n | input | 1 | Maskable interrupt pin, active low |
| xirq_n | input | 1 | Nonmaskable interrupt pin, active low |
| rst_pin_n | input | 1 | External reset pin, active low |
| irq_edge_pend | input | 1 | Pending edge-latched maskable interrupt |
| settle_cnt | input | 12 | Settling cycles after wake, 0 selects the default |
| osc_en | output | 1 | Crystal oscillator enable |
| core_clk_en | output | 1 | Core and peripheral clock enable |
| stop_active | output | 1 | Halt or settling in progress |
| nop_ack | output | 1 | Stop opcode treated as no-op |
| wake_valid | output | 1 | Wake action code valid this cycle |
| wake_action | output | 3 | 0 none, 1 take IRQ, 2 take XIRQ, 3 continue, 4 full reset |

## Verification
The wake logic is driven with each source alone: IRQ level, pending IRQ edge, XIRQ with each mask value, and the reset pin. Each run separates the qualification rule from the action coding. Masked IRQ and a repeated stop strobe while halted show that ignored stimulus really leaves the clocks off. Two and three sources asserted in the same cycle show the priority order. Settle counts of 1, 5 and 0 check the exact release cycle, including the default count.

// File: rtl/stop_wake_pkg.sv
package stop_wake_pkg;

   typedef enum logic [1:0] {
      ST_RUN    = 2'd0,
      ST_HALT   = 2'd1,
      ST_SETTLE = 2'd2
   } pm_state_t;

   typedef enum logic [2:0] {
      ACT_NONE  = 3'd0,
      ACT_IRQ   = 3'd1,
      ACT_XIRQ  = 3'd2,
      ACT_NEXT  = 3'd3,
      ACT_RESET = 3'd4
   } wake_act_t;

endpackage

// File: rtl/stop_wake_arb.sv
module stop_wake_arb
   import stop_wake_pkg::*;
#(
   parameter bit EDGE_WAKE = 1'b1
) (
   input  logic      irq_n,
   input  logic      xirq_n,
   input  logic      rst_pin_n,
   input  logic      irq_edge_pend,
   input  logic      irq_mask,
   input  logic      xirq_mask,
   output logic      wake,
   output wake_act_t act
);

   logic irq_src;

   generate
      if (EDGE_WAKE) begin : g_edge
         assign irq_src = !irq_n || irq_edge_pend;
      end else begin : g_level
         assign irq_src = !irq_n;
      end
   endgenerate

   always_comb begin
      wake = 1'b1;
      act  = ACT_NONE;
      if (!rst_pin_n) begin
         act = ACT_RESET;
      end else if (!xirq_n) begin
         act = xirq_mask ? ACT_NEXT : ACT_XIRQ;
      end else if (irq_src && !irq_mask) begin
         act = ACT_IRQ;
      end else begin
         wake = 1'b0;
      end
   end

endmodule

// File: rtl/stop_settle_timer.sv
module stop_settle_timer #(
   parameter int W   = 12,
   parameter int DEF = 4064
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         en,
   output logic         last
);

   localparam logic [W-1:0] DEF_V = W'(DEF);

   generate
      if (W < 2) begin : g_bad_w
         $error("stop_settle_timer: W must be at least 2");
      end
      if (DEF < 1 || DEF >= (1 << W)) begin : g_bad_def
         $error("stop_settle_timer: DEF must fit in W bits and be nonzero");
      end
   endgenerate

   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (load) begin
         cnt <= (load_val == '0) ? DEF_V : load_val;
      end else if (en && !last) begin
         cnt <= cnt - 1'b1;
      end
   end

   assign last = (cnt <= W'(1));

   // R9
   no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      en |-> (cnt != '0));

endmodule

// File: rtl/stop_wake_ctrl.sv
module stop_wake_ctrl
   import stop_wake_pkg::*;
#(
   parameter int SETTLE_W   = 12,
   parameter int SETTLE_DEF = 4064,
   parameter bit EDGE_WAKE  = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                stop_exec,
   input  logic                stop_dis,
   input  logic                irq_mask,
   input  logic                xirq_mask,
   input  logic                irq_n,
   input  logic                xirq_n,
   input  logic                rst_pin_n,
   input  logic                irq_edge_pend,
   input  logic [SETTLE_W-1:0] settle_cnt,
   output logic                osc_en,
   output logic                core_clk_en,
   output logic                stop_active,
   output logic                nop_ack,
   output logic                wake_valid,
   output logic [2:0]          wake_action
);

   pm_state_t state;
   wake_act_t act_pend, act_out;
   logic      nop_q, wv_q;
   logic      arb_wake, tmr_last, tmr_load, tmr_en;
   wake_act_t arb_act;

   stop_wake_arb #(.EDGE_WAKE(EDGE_WAKE)) u_arb (
      .irq_n         (irq_n),
      .xirq_n        (xirq_n),
      .rst_pin_n     (rst_pin_n),
      .irq_edge_pend (irq_edge_pend),
      .irq_mask      (irq_mask),
      .xirq_mask     (xirq_mask),
      .wake          (arb_wake),
      .act           (arb_act)
   );

   assign tmr_load = (state == ST_HALT) && arb_wake;
   assign tmr_en   = (state == ST_SETTLE);

   stop_settle_timer #(.W(SETTLE_W), .DEF(SETTLE_DEF)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (settle_cnt),
      .en       (tmr_en),
      .last     (tmr_last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_RUN;
         act_pend <= ACT_NONE;
         act_out  <= ACT_NONE;
         nop_q    <= 1'b0;
         wv_q     <= 1'b0;
      end else begin
         nop_q   <= (state == ST_RUN) && stop_exec && stop_dis;
         wv_q    <= 1'b0;
         act_out <= ACT_NONE;
         case (state)
            ST_RUN: begin
               if (stop_exec && !stop_dis) state <= ST_HALT;
            end
            ST_HALT: begin
               if (arb_wake) begin
                  state    <= ST_SETTLE;
                  act_pend <= arb_act;
               end
            end
            ST_SETTLE: begin
               if (tmr_last) begin
                  state   <= ST_RUN;
                  wv_q    <= 1'b1;
                  act_out <= act_pend;
               end
            end
            default: state <= ST_RUN;
         endcase
      end
   end

   assign osc_en      = (state != ST_HALT);
   assign core_clk_en = (state == ST_RUN);
   assign stop_active = (state != ST_RUN);
   assign nop_ack     = nop_q;
   assign wake_valid  = wv_q;
   assign wake_action = act_out;

   // R1
   stop_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RUN && stop_exec && !stop_dis) |=>
         (!osc_en && !core_clk_en && stop_active));

   // R2
   nop_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RUN && stop_exec && stop_dis) |=> (nop_ack && core_clk_en));

   // R4
   masked_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_HALT && rst_pin_n && xirq_n && irq_mask) |=> !osc_en);

   // R5
   xirq_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_HALT && !xirq_n) |=> osc_en);

   // R8
   reset_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_HALT && !rst_pin_n) |=> (act_pend == ACT_RESET));

   // R10
   release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wake_valid |-> (core_clk_en && $past(stop_active)));

   // R10
   act_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wake_valid |-> (wake_action == 3'd0));

endmodule

// File: tb/stop_wake_ctrl_test.sv
module stop_wake_ctrl_test;

   localparam int W   = 12;
   localparam int DEF = 4064;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic         rst_n = 1'b0;
   logic         stop_exec = 1'b0, stop_dis = 1'b0;
   logic         irq_mask = 1'b1, xirq_mask = 1'b1;
   logic         irq_n = 1'b1, xirq_n = 1'b1, rst_pin_n = 1'b1, irq_edge = 1'b0;
   logic [W-1:0] settle = 12'd5;
   logic         osc_en, core_clk_en, stop_active, nop_ack, wake_valid;
   logic [2:0]   wake_action;

   stop_wake_ctrl uut (
      .clk(clk), .rst_n(rst_n), .stop_exec(stop_exec), .stop_dis(stop_dis),
      .irq_mask(irq_mask), .xirq_mask(xirq_mask), .irq_n(irq_n), .xirq_n(xirq_n),
      .rst_pin_n(rst_pin_n), .irq_edge_pend(irq_edge), .settle_cnt(settle),
      .osc_en(osc_en), .core_clk_en(core_clk_en), .stop_active(stop_active),
      .nop_ack(nop_ack), .wake_valid(wake_valid), .wake_action(wake_action)
   );

   int    errors = 0, checks = 0;
   bit    done = 1'b0;
   string req = "R10";

   // behavioural reference: 0 running, 1 halted, 2 settling
   int m_st = 0, m_cnt = 0, m_pend = 0, m_nop = 0, m_wv = 0, m_wa = 0;

   task automatic model_step();
      int  old;
      bit  rw, xw, iw;
      if (!rst_n) begin
         m_st = 0; m_nop = 0; m_wv = 0; m_wa = 0;
      end else begin
         old   = m_st;
         m_nop = (old == 0 && stop_exec && stop_dis) ? 1 : 0;
         m_wv  = 0;
         m_wa  = 0;
         if (old == 0) begin
            if (stop_exec && !stop_dis) m_st = 1;
         end else if (old == 1) begin
            rw = !rst_pin_n;
            xw = !xirq_n;
            iw = (!irq_n || irq_edge) && !irq_mask;
            if (rw || xw || iw) begin
               if (rw)      m_pend = 4;
               else if (xw) m_pend = xirq_mask ? 3 : 2;
               else         m_pend = 1;
               m_cnt = (settle == 0) ? DEF : int'(settle);
               m_st  = 2;
            end
         end else begin
            if (m_cnt <= 1) begin
               m_st = 0; m_wv = 1; m_wa = m_pend;
            end else begin
               m_cnt = m_cnt - 1;
            end
         end
      end
   endtask

   task automatic check(string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic cyc();
      @(posedge clk);
      model_step();
      #2;
      check("osc_en",      int'(osc_en),      (m_st != 1) ? 1 : 0);
      check("core_clk_en", int'(core_clk_en), (m_st == 0) ? 1 : 0);
      check("stop_active", int'(stop_active), (m_st != 0) ? 1 : 0);
      check("nop_ack",     int'(nop_ack),     m_nop);
      check("wake_valid",  int'(wake_valid),  m_wv);
      check("wake_action", int'(wake_action), m_wa);
   endtask

   task automatic run(int n);
      for (int i = 0; i < n; i++) cyc();
   endtask

   task automatic enter_stop();
      stop_dis  = 1'b0;
      stop_exec = 1'b1;
      cyc();
      stop_exec = 1'b0;
      cyc();
   endtask

   task automatic release_pins();
      irq_n = 1'b1; xirq_n = 1'b1; rst_pin_n = 1'b1; irq_edge = 1'b0;
   endtask

   initial begin
      req = "R10";
      run(3);
      rst_n = 1'b1;
      run(2);

      // R2: disabled stop is a no-op
      req = "R2";
      stop_dis = 1'b1; stop_exec = 1'b1; cyc();
      stop_exec = 1'b0; run(3);

      // R1 entry, R3 idle and repeated strobe, R4 masked then unmasked IRQ
      req = "R1";
      enter_stop();
      req = "R3";
      run(10);
      stop_dis = 1'b1; stop_exec = 1'b1; cyc();
      stop_exec = 1'b0; stop_dis = 1'b0; run(3);
      req = "R4";
      irq_mask = 1'b1; irq_n = 1'b0; irq_edge = 1'b1; run(6);
      irq_edge = 1'b0; irq_mask = 1'b0; run(2);
      release_pins();
      req = "R9";
      run(8);

      // R4 / R6: pending edge alone wakes with IRQ action
      req = "R6";
      enter_stop();
      irq_edge = 1'b1; run(2); release_pins(); run(8);

      // R5 / R6: XIRQ with mask clear, then with mask set
      req = "R5";
      irq_mask = 1'b1; xirq_mask = 1'b0;
      enter_stop();
      xirq_n = 1'b0; run(2); release_pins(); run(8);
      xirq_mask = 1'b1;
      enter_stop();
      xirq_n = 1'b0; run(2); release_pins(); run(8);

      // R7: reset pin
      req = "R7";
      enter_stop();
      rst_pin_n = 1'b0; run(2); release_pins(); run(8);

      // R8: priority among simultaneous sources
      req = "R8";
      irq_mask = 1'b0; xirq_mask = 1'b0;
      enter_stop();
      rst_pin_n = 1'b0; xirq_n = 1'b0; irq_n = 1'b0; run(2); release_pins(); run(8);
      enter_stop();
      xirq_n = 1'b0; irq_n = 1'b0; run(2); release_pins(); run(8);

      // R9: shortest settle and default settle
      req = "R9";
      settle = 12'd1;
      enter_stop();
      irq_n = 1'b0; cyc(); release_pins(); run(5);
      settle = 12'd0;
      enter_stop();
      xirq_n = 1'b0; cyc(); release_pins(); run(DEF + 6);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule